// File: doc/BRIEF.md
# Parallel sampling-ADC read controller

This block sits between a system clock domain and an external 16-bit sampling converter with a parallel output bus. When a start request arrives, or when an optional internal sample timer expires, it drives an active-low conversion pulse. Conversion begins on the rising edge of that pulse. The controller then follows the converter's busy line. It first brings that line into the clock domain through a synchronizer. It waits for busy to go low and then high again, and after that it fetches the two's-complement result.

The result can be fetched in three ways. In word mode a single 16-bit read strobe is used. In byte mode two 8-bit reads are made, upper half first, with a half-select line choosing the byte. In free-running mode chip select and read stay low all the time and the word is captured when busy rises. Every pulse width, setup gap and release gap is a cycle count rounded up from a nanosecond parameter. A busy line that never completes its handshake is ended by a timeout, which sets a sticky error flag. The finished word is offered on a valid/ready output and held until it is taken.

Top module: `adc_read_ctrl`

## Requirements
- R1: Each accepted trigger drives `adcConvN` low for exactly ceil(CONV_PULSE_NS/CLK_PERIOD_NS) cycles (10 at defaults), after which it returns high.
- R2: `adcBusy` passes through a two-stage synchronizer. In word and byte mode, no read strobe is issued until busy has been seen low and then high again.
- R3: In word mode (`busMode` 0, and also the unused code 3), one strobe is made with `adcCsN` and `adcRdN` both low. The strobe lasts max(ceil(RD_PULSE_NS/T), ceil(ACCESS_NS/T)+1) cycles (13 at defaults). `outData` then equals the 16-bit bus value.
- R4: In byte mode (`busMode` 1), two strobes of the R3 width are made. During the first, `adcHiByte` is 1 and `adcData[7:0]` carries result bits 15..8. During the second, `adcHiByte` is 0 and the same lines carry bits 7..0. `adcHiByte` does not change while a strobe is low. The strobes are separated by at least ceil(RELEASE_NS/T) high cycles. `outData` is the two bytes joined, upper byte first.
- R5: In free-running mode (`busMode` 2), `adcCsN` and `adcRdN` are held low. The word on `adcData` is captured when the synchronized busy rises, and no read strobes are made.
- R6: `outValid` rises only once the whole word is assembled. It stays high with `outData` unchanged until a cycle in which `outReady` is high. The cycle after that handshake, `outValid` is low.
- R7: A trigger that arrives while a conversion, read or delivery is in progress is ignored and produces no extra conversion pulse.
- R8: If busy has not finished its low-then-high handshake within ceil(TIMEOUT_NS/T) cycles (2000 at defaults) after the conversion pulse ends, the controller returns to idle without asserting `outValid`. `errTimeout` then goes high and stays high until reset.
- R9: While `timerEn` is high, a trigger is raised every ceil(SAMPLE_NS/T) cycles (1200 at defaults). A timer trigger that comes while the controller is busy is lost.
- R10: Codes are passed through unaltered, including positive full scale 0x7FFF and negative full scale 0x8000.
- R11: After reset, `adcConvN`, `adcCsN` and `adcRdN` are high, and `outValid` and `errTimeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion |
| timerEn | input | 1 | Enable the internal sample timer |
| busMode | input | 2 | 0 word, 1 byte, 2 free-running, 3 word |
| adcConvN | output | 1 | Active-low conversion pulse; conversion starts on its rising edge |
| adcCsN | output | 1 | Active-low chip select |
| adcRdN | output | 1 | Active-low read strobe |
| adcHiByte | output | 1 | Byte select: 1 upper half, 0 lower half |
| adcBusy | input | 1 | Converter busy, low during conversion (asynchronous) |
| adcData | input | 16 | Converter data bus; byte mode uses bits 7..0 |
| outValid | output | 1 | Result word available |
| outReady | input | 1 | Consumer takes the word |
| outData | output | 16 | Two's-complement result |
| errTimeout | output | 1 | Sticky busy-timeout flag |

## Verification
Each bus mode is swept with full-scale codes, zero, all ones and a walking single one. A walking one shows whether the upper and lower bytes are swapped or dropped in reassembly. The converter model puts a filler pattern on the bus whenever it is not being read, and non-zero junk on the upper lines in byte mode. A capture at the wrong moment, or from the wrong lines, therefore shows up as a mismatch. Stray start requests are sent during conversion and during delivery, and consumer stalls of different lengths are applied. A converter with a stuck busy line tests the timeout just before and just after its limit. Timer spacing is measured edge to edge.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [1:0] {
    MODE_WORD = 2'd0,
    MODE_BYTE = 2'd1,
    MODE_FREE = 2'd2,
    MODE_RSVD = 2'd3
  } busMode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CONV, S_WAIT_LO, S_WAIT_HI, S_SETUP, S_RD, S_GAP, S_DELIVER
  } state_e;

  // capture strobes from control to datapath
  typedef struct packed {
    logic capWord;
    logic capHi;
    logic capLo;
  } capStrobe_t;

  function automatic int unsigned cycCeil(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_read_path.sv
`timescale 1ns/1ps
module adc_read_path
  import adc_rd_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcBusy,
  input  logic [WORD_W-1:0] adcData,
  input  capStrobe_t        cap,
  output logic              busyLvl,
  output logic [WORD_W-1:0] outData
);
  localparam int unsigned BYTE_W = WORD_W / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [BYTE_W-1:0]      hiQ;

  // busy synchronizer chain, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], adcBusy};
  end
  assign busyLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ     <= '0;
      outData <= '0;
    end else begin
      if (cap.capHi)   hiQ     <= adcData[BYTE_W-1:0];
      if (cap.capLo)   outData <= {hiQ, adcData[BYTE_W-1:0]};
      if (cap.capWord) outData <= adcData;
    end
  end

  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cap.capWord, cap.capHi, cap.capLo})); // R3

endmodule

// File: rtl/adc_read_fsm.sv
`timescale 1ns/1ps
module adc_read_fsm
  import adc_rd_pkg::*;
#(
  parameter int unsigned START_CYC  = 10,
  parameter int unsigned RD_CYC     = 13,
  parameter int unsigned REL_CYC    = 10,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned TMO_CYC    = 2000,
  parameter int unsigned SAMPLE_CYC = 1200,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned TMO_W      = 11,
  parameter int unsigned SMP_W      = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       timerEn,
  input  logic [1:0] busMode,
  input  logic       busyLvl,
  input  logic       outReady,
  output logic       adcConvN,
  output logic       adcCsN,
  output logic       adcRdN,
  output logic       adcHiByte,
  output logic       outValid,
  output logic       errTimeout,
  output capStrobe_t cap
);
  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic [SMP_W-1:0] smp;
  logic             phase;
  logic             errQ;
  busMode_e         mode;
  logic             freeMode, byteMode, timerTick, trigger, tmoHit, cntDone;

  assign mode      = busMode_e'(busMode);
  assign freeMode  = (mode == MODE_FREE);
  assign byteMode  = (mode == MODE_BYTE);
  assign timerTick = timerEn && (smp == SMP_W'(SAMPLE_CYC - 1));
  assign trigger   = startReq || timerTick;
  assign tmoHit    = (tmo == TMO_W'(TMO_CYC - 1));
  assign cntDone   = (cnt == '0);

  // free-running sample timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     smp <= '0;
    else if (!timerEn || timerTick) smp <= '0;
    else                           smp <= smp + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      tmo   <= '0;
      phase <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (trigger) begin
          state <= S_CONV;
          cnt   <= CNT_W'(START_CYC - 1);
          phase <= 1'b0;
        end
        S_CONV: begin
          if (cntDone) begin
            state <= S_WAIT_LO;
            tmo   <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_WAIT_LO: begin
          tmo <= tmo + 1'b1;
          if (!busyLvl) state <= S_WAIT_HI;
          else if (tmoHit) begin
            state <= S_IDLE;
            errQ  <= 1'b1;
          end
        end
        S_WAIT_HI: begin
          tmo <= tmo + 1'b1;
          if (busyLvl) begin
            if (freeMode) state <= S_DELIVER;
            else begin
              state <= S_SETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end
          end else if (tmoHit) begin
            state <= S_IDLE;
            errQ  <= 1'b1;
          end
        end
        S_SETUP: begin
          if (cntDone) begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_RD: begin
          if (cntDone) begin
            state <= S_GAP;
            cnt   <= CNT_W'(REL_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_GAP: begin
          if (cntDone) begin
            if (byteMode && !phase) begin
              phase <= 1'b1;
              state <= S_SETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end else state <= S_DELIVER;
          end else cnt <= cnt - 1'b1;
        end
        S_DELIVER: if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cap.capWord = (state == S_RD && cntDone && !byteMode) ||
                       (state == S_WAIT_HI && busyLvl && freeMode);
  assign cap.capHi   = (state == S_RD) && cntDone && byteMode && !phase;
  assign cap.capLo   = (state == S_RD) && cntDone && byteMode && phase;

  assign adcConvN   = (state != S_CONV);
  assign adcCsN     = !(freeMode || state == S_RD);
  assign adcRdN     = !(freeMode || state == S_RD);
  assign adcHiByte  = byteMode && !phase;
  assign outValid   = (state == S_DELIVER);
  assign errTimeout = errQ;

  AST_HB_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!adcRdN && $past(!adcRdN)) |-> $stable(adcHiByte)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |=> errTimeout); // R8

  generate
    if (START_CYC > 1) begin : g_convMin
      AST_CONV_MIN: assert property (@(posedge clk) disable iff (!rstN)
        $fell(adcConvN) |=> !adcConvN); // R1
    end
    if (RD_CYC > 1) begin : g_rdMin
      AST_RD_MIN: assert property (@(posedge clk) disable iff (!rstN)
        ($fell(adcRdN) && !freeMode) |=> !adcRdN); // R3
    end
  endgenerate

endmodule

// File: rtl/adc_read_ctrl.sv
`timescale 1ns/1ps
module adc_read_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned CONV_PULSE_NS = 50,
  parameter int unsigned RD_PULSE_NS   = 60,
  parameter int unsigned ACCESS_NS     = 57,
  parameter int unsigned RELEASE_NS    = 50,
  parameter int unsigned HB_SETUP_NS   = 10,
  parameter int unsigned TIMEOUT_NS    = 10000,
  parameter int unsigned SAMPLE_NS     = 6000,
  parameter int unsigned WORD_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              timerEn,
  input  logic [1:0]        busMode,
  output logic              adcConvN,
  output logic              adcCsN,
  output logic              adcRdN,
  output logic              adcHiByte,
  input  logic              adcBusy,
  input  logic [WORD_W-1:0] adcData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              errTimeout
);
  localparam int unsigned START_CYC  = maxU(1, cycCeil(CONV_PULSE_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_CYC     = maxU(cycCeil(RD_PULSE_NS, CLK_PERIOD_NS),
                                            cycCeil(ACCESS_NS, CLK_PERIOD_NS) + 1);
  localparam int unsigned REL_CYC    = maxU(1, cycCeil(RELEASE_NS, CLK_PERIOD_NS));
  localparam int unsigned SETUP_CYC  = maxU(1, cycCeil(HB_SETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned TMO_CYC    = maxU(2, cycCeil(TIMEOUT_NS, CLK_PERIOD_NS));
  localparam int unsigned SAMPLE_CYC = maxU(2, cycCeil(SAMPLE_NS, CLK_PERIOD_NS));
  localparam int unsigned CNT_MAX    = maxU(maxU(START_CYC, RD_CYC), maxU(REL_CYC, SETUP_CYC));
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
  localparam int unsigned TMO_W      = $clog2(TMO_CYC + 1);
  localparam int unsigned SMP_W      = $clog2(SAMPLE_CYC + 1);

  capStrobe_t cap;
  logic       busyLvl;

  adc_read_fsm #(
    .START_CYC (START_CYC), .RD_CYC (RD_CYC), .REL_CYC (REL_CYC),
    .SETUP_CYC (SETUP_CYC), .TMO_CYC (TMO_CYC), .SAMPLE_CYC (SAMPLE_CYC),
    .CNT_W (CNT_W), .TMO_W (TMO_W), .SMP_W (SMP_W)
  ) i_fsm (
    .clk, .rstN, .startReq, .timerEn, .busMode, .busyLvl, .outReady,
    .adcConvN, .adcCsN, .adcRdN, .adcHiByte, .outValid, .errTimeout, .cap
  );

  adc_read_path #(.WORD_W (WORD_W), .SYNC_STAGES (2)) i_path (
    .clk, .rstN, .adcBusy, .adcData, .cap, .busyLvl, .outData
  );

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R6

  AST_NO_RD_IN_CONV: assert property (@(posedge clk) disable iff (!rstN)
    (!busyLvl && busMode != 2'd2) |-> adcRdN); // R2

endmodule

// File: tb/test_adc_read_ctrl.sv
`timescale 1ns/1ps
module test_adc_read_ctrl;
  localparam int START_CYC  = (50 + 4) / 5;
  localparam int RD_CYC     = ((57 + 4) / 5 + 1 > (60 + 4) / 5) ? (57 + 4) / 5 + 1 : (60 + 4) / 5;
  localparam int REL_CYC    = (50 + 4) / 5;
  localparam int SAMPLE_CYC = (6000 + 4) / 5;

  logic clk = 0, rstN = 0, startReq = 0, timerEn = 0, outReady = 0;
  logic [1:0] busMode = 0;
  logic adcConvN, adcCsN, adcRdN, adcHiByte, outValid, errTimeout;
  logic adcBusy = 1;
  logic [15:0] adcData, outData;
  logic [15:0] latched = 16'h0, sampleNext = 16'h0;
  bit armed = 0, hangBusy = 0;
  int nChecks = 0, nFail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adc_read_ctrl i_adc_read_ctrl (
    .clk, .rstN, .startReq, .timerEn, .busMode, .adcConvN, .adcCsN, .adcRdN,
    .adcHiByte, .adcBusy, .adcData, .outValid, .outReady, .outData, .errTimeout
  );

  // converter model
  always @(posedge adcConvN) if (armed && !hangBusy) begin
    #30 adcBusy = 0;
    #300 latched = sampleNext;
    #50 adcBusy = 1;
  end
  assign adcData = (busMode == 2'd2) ? latched :
                   (!adcCsN && !adcRdN) ?
                     ((busMode == 2'd1) ? {8'hEE, adcHiByte ? latched[15:8] : latched[7:0]} : latched)
                   : 16'hC3C3;

  // observers
  int convRun = 0, lastConvLow = 0, convPulses = 0;
  int rdRun = 0, lastRdLow = 0, rdStrobes = 0, highRun = 0, lastGap = 0;
  int hbBadCnt = 0, rdConvCnt = 0;
  logic hbPrev = 0;
  logic hbLog [4];
  always @(negedge clk) begin
    if (!adcConvN) convRun++;
    else if (convRun != 0) begin lastConvLow = convRun; convPulses++; convRun = 0; end
    if (!adcRdN) begin
      if (rdRun == 0) begin hbLog[rdStrobes % 4] = adcHiByte; lastGap = highRun; end
      else if (adcHiByte != hbPrev) hbBadCnt++;
      hbPrev = adcHiByte; rdRun++; highRun = 0;
      if (!adcBusy && busMode != 2'd2) rdConvCnt++;
    end else begin
      highRun++;
      if (rdRun != 0) begin lastRdLow = rdRun; rdStrobes++; rdRun = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic runConv(input logic [15:0] val, input logic [1:0] mode, input int readyDelay, input string req);
    int p0, s0, b0, c0, n, expStrobes;
    busMode = mode; sampleNext = val;
    repeat (2) @(negedge clk);
    p0 = convPulses; s0 = rdStrobes; b0 = hbBadCnt; c0 = rdConvCnt;
    startReq = 1; @(negedge clk); startReq = 0;
    repeat (6) @(negedge clk);
    startReq = 1; @(negedge clk); startReq = 0;   // R7: request during conversion
    n = 0;
    while (!outValid && n < 4000) begin @(negedge clk); n++; end
    check(outValid && outData == val, req, outData, val);
    check(convPulses == p0 + 1, "R7", convPulses - p0, 1);
    check(lastConvLow == START_CYC, "R1", lastConvLow, START_CYC);
    expStrobes = (mode == 2'd1) ? 2 : (mode == 2'd2) ? 0 : 1;
    check(rdStrobes - s0 == expStrobes, (mode == 2'd1) ? "R4" : (mode == 2'd2) ? "R5" : "R3",
          rdStrobes - s0, expStrobes);
    if (expStrobes != 0) check(lastRdLow == RD_CYC, "R3", lastRdLow, RD_CYC);
    if (mode == 2'd1) begin
      check(hbLog[s0 % 4] == 1'b1 && hbLog[(s0 + 1) % 4] == 1'b0 && hbBadCnt == b0,
            "R4", {hbLog[s0 % 4], hbLog[(s0 + 1) % 4]}, 2'b10);
      check(lastGap >= REL_CYC, "R4", lastGap, REL_CYC);
    end
    if (mode == 2'd2) check(!adcCsN && !adcRdN, "R5", {adcCsN, adcRdN}, 0);
    check(rdConvCnt == c0, "R2", rdConvCnt - c0, 0);
    if (readyDelay > 0) begin
      startReq = 1; @(negedge clk); startReq = 0;   // R7: request during delivery
      repeat (readyDelay - 1) @(negedge clk);
      check(outValid && outData == val, "R6", outData, val);
    end
    outReady = 1; @(negedge clk); outReady = 0;
    check(!outValid, "R6", outValid, 0);
    if (readyDelay > 0) begin
      repeat (START_CYC + 3) @(negedge clk);
      check(convPulses == p0 + 1 && adcConvN, "R7", convPulses - p0, 1);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(adcConvN && adcCsN && adcRdN && !outValid && !errTimeout, "R11",
          {adcConvN, adcCsN, adcRdN, outValid, errTimeout}, 5'b11100);
    rstN = 1; armed = 1;
    repeat (3) @(negedge clk);
    check(adcConvN && adcCsN && adcRdN && !outValid && !errTimeout, "R11",
          {adcConvN, adcCsN, adcRdN, outValid, errTimeout}, 5'b11100);

    // full-scale codes in every mode
    for (int m = 0; m < 4; m++) begin
      runConv(16'h7FFF, m[1:0], m, "R10");
      runConv(16'h8000, m[1:0], 0, "R10");
    end
    // walking one / walking zero sweeps
    for (int b = 0; b < 16; b++) begin
      runConv(16'h1 << b, 2'd1, b % 3, "R4");
      runConv(~(16'h1 << b), 2'd0, (b + 1) % 3, "R3");
    end
    runConv(16'h0000, 2'd2, 2, "R5");
    runConv(16'hFFFF, 2'd2, 0, "R5");
    runConv(16'hA5C3, 2'd2, 1, "R5");
    runConv(16'h00FF, 2'd1, 0, "R4");
    runConv(16'hFF00, 2'd1, 2, "R4");

    // R8: stuck busy
    busMode = 2'd0; hangBusy = 1;
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
    repeat (1900) @(negedge clk);
    check(!errTimeout, "R8", errTimeout, 0);
    repeat (200) @(negedge clk);
    check(errTimeout && !outValid && adcRdN, "R8", {errTimeout, outValid, adcRdN}, 3'b101);
    hangBusy = 0;
    runConv(16'h1357, 2'd0, 0, "R8");
    check(errTimeout, "R8", errTimeout, 1);

    // R9: internal timer
    outReady = 1; busMode = 2'd0;
    @(negedge clk); timerEn = 1;
    n = 0;
    while (adcConvN && n < 3000) begin @(negedge clk); n++; end
    check(n >= SAMPLE_CYC - 2 && n <= SAMPLE_CYC + 2, "R9", n, SAMPLE_CYC);
    while (!adcConvN) @(negedge clk);
    n = 1;
    while (adcConvN && n < 3000) begin @(negedge clk); n++; end
    n = n + START_CYC - 1;
    check(n == SAMPLE_CYC, "R9", n, SAMPLE_CYC);
    timerEn = 0; outReady = 0;
    repeat (400) @(negedge clk);

    summary();
    $finish;
  end
endmodule